// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Read-Out Port

This block models the digital output side of a decimating converter. A fast system clock `clk` samples the converter master clock pin `mclk`, and every detected rising edge of `mclk` advances a frame counter. Once per frame the block pulls the active-low ready strobe `drdyN` down and, on that same edge, captures the 24-bit result presented on `convData` into a shift register.

A host reads the word by pulling `csN` low and toggling `sclk`. The port drives `sdoOe` while `csN` is low. The pin `sclk` is also sampled on `clk`, and each falling edge that the block detects moves the word one place towards `sdo`, most significant bit first. The bit entering at the bottom is taken from `sdi`. A chain of ports can therefore be read as one long word: the local word comes out first, then the upstream data.

The active-low pin `syncPdN` stops conversion reporting. When it is released, the filter has to settle for a fixed number of `mclk` edges before the next ready strobe. The same settling applies after reset.

Top module: `sd_adc_serial_port`

## Requirements
- R1: A rising edge of `mclk` is counted when `mclk` is sampled high on `clk` after being sampled low. In steady running, `drdyN` falls once every 32 counted edges. It is high for exactly one of those 32 edge-to-edge intervals, whatever the `mclk` duty cycle between 1/8 and 7/8.
- R2: The value on `convData` at the `clk` edge where `drdyN` falls is loaded into the shift register. Its bit 23 appears on `sdo` from that same edge, so a host that already holds `csN` low sees it with no `sclk` activity.
- R3: `sdoOe` is 1 exactly while `csN` is 0. It is 0 while `csN` is 1, and `sdo` carries no meaning then.
- R4: With `csN` low, a detected `sclk` falling edge (sampled 0 after sampled 1) shifts the register one place towards the MSB. `sdo` then shows the next lower bit of the word and holds it until the next detected falling edge.
- R5: While `csN` is high, `sclk` edges do not move the shift register. The word read after `csN` falls still starts at bit 23.
- R6: On every shift, the value of `sdi` at that edge enters at bit 0. After 24 shifts, the `sdi` bits come out on `sdo` in the order they were presented.
- R7: A counted `mclk` edge that samples `syncPdN` low leaves `drdyN` high after it. While `syncPdN` stays low, `drdyN` never falls and no new word is loaded.
- R8: A counted `mclk` edge that samples `syncPdN` high after power-down starts the settling period. `drdyN` falls on the 2357th counted edge after that one. After reset, `drdyN` falls on the 2357th counted edge.
- R9: During reset, `drdyN` is 1, the shift register is zero (so `sdo` is 0), and `sdoOe` still follows `csN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rstN | input | 1 | Active-low synchronous reset |
| mclk | input | 1 | Converter master clock pin, sampled |
| syncPdN | input | 1 | Active-low sync / power-down request |
| convData | input | 24 | Parallel conversion result |
| csN | input | 1 | Active-low read select |
| sclk | input | 1 | Serial read clock, sampled |
| sdi | input | 1 | Upstream chain data |
| drdyN | output | 1 | Active-low data-ready strobe |
| sdo | output | 1 | Serial data bit |
| sdoOe | output | 1 | Output enable for `sdo` |

## Verification
The assertions assume that `mclk` and `sclk` each stay at a level for at least one `clk` cycle, so that no edge is lost between samples. They also assume that a host raises `csN` before `drdyN` rises, so a shift never meets a load. The bench drives every pin on falling `clk` edges and holds each `mclk` and `sclk` level for at least one full cycle. Each read of 48 bits ends well inside the 31-interval low window of `drdyN`, and `syncPdN` is held high through every settling period.

// File: rtl/sd_adc_pkg.sv
package sd_adc_pkg;
  typedef enum logic [1:0] {
    ST_PD,
    ST_SETTLE,
    ST_RUN
  } adcState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobes_t;
endpackage

// File: rtl/sd_adc_ctrl.sv
module sd_adc_ctrl
  import sd_adc_pkg::*;
#(
  parameter int FRAME_LEN     = 32,
  parameter int SETTLE_CYCLES = 2357
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mclk,
  input  logic       sclk,
  input  logic       csN,
  input  logic       syncPdN,
  output logic       drdyN,
  output dpStrobes_t strb
);
  localparam int FRAME_W  = $clog2(FRAME_LEN);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES);

  adcState_t            state;
  logic [FRAME_W-1:0]   frameCnt;
  logic [SETTLE_W-1:0]  settleCnt;
  logic                 mclkQ, sclkQ;
  logic                 mclkRise, frameEnd, settleDone;

  assign mclkRise   = mclk & ~mclkQ;
  assign frameEnd   = (frameCnt == FRAME_W'(FRAME_LEN - 1));
  assign settleDone = (settleCnt == SETTLE_W'(SETTLE_CYCLES - 1));

  always_comb begin
    strb.shift = sclkQ & ~sclk & ~csN;
    strb.load  = mclkRise & syncPdN &
                 (((state == ST_SETTLE) & settleDone) | ((state == ST_RUN) & frameEnd));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      frameCnt  <= '0;
      settleCnt <= '0;
      drdyN     <= 1'b1;
      mclkQ     <= 1'b0;
      sclkQ     <= 1'b0;
    end else begin
      mclkQ <= mclk;
      sclkQ <= sclk;
      if (mclkRise) begin
        if (!syncPdN) begin
          state <= ST_PD;
          drdyN <= 1'b1;
        end else begin
          case (state)
            ST_PD: begin
              state     <= ST_SETTLE;
              settleCnt <= '0;
            end
            ST_SETTLE: begin
              if (settleDone) begin
                state    <= ST_RUN;
                frameCnt <= '0;
                drdyN    <= 1'b0;
              end else begin
                settleCnt <= settleCnt + 1'b1;
              end
            end
            default: begin
              if (frameEnd) begin
                frameCnt <= '0;
                drdyN    <= 1'b0;
              end else begin
                frameCnt <= frameCnt + 1'b1;
                if (frameCnt == FRAME_W'(FRAME_LEN - 2)) drdyN <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  // R7: a sampled low request forces the strobe high after that mclk edge
  assert_pd_forces_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mclkRise && !syncPdN) |=> drdyN);

  // R1: the high phase of the strobe lasts a single mclk interval
  assert_high_one_interval_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mclkRise && syncPdN && state == ST_RUN && drdyN) |=> !drdyN);

  // R8: no ready strobe outside steady running
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN) |-> drdyN);
endmodule

// File: rtl/sd_adc_datapath.sv
module sd_adc_datapath
  import sd_adc_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [WORD_W-1:0] convData,
  input  logic              sdi,
  output logic              sdo
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rstN)           shreg <= '0;
    else if (strb.load)  shreg <= convData;
    else if (strb.shift) shreg <= {shreg[WORD_W-2:0], sdi};
  end

  assign sdo = shreg[WORD_W-1];

  // R4: the word holds still when neither a load nor a shift was requested
  assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.load) && !$past(strb.shift)) |-> $stable(shreg));

  // R6: a shift takes the chain input into the bottom bit
  assert_chain_enters_lsb_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.shift) && !$past(strb.load)) |-> shreg[0] == $past(sdi));
endmodule

// File: rtl/sd_adc_serial_port.sv
module sd_adc_serial_port
  import sd_adc_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int FRAME_LEN     = 32,
  parameter int SETTLE_CYCLES = 2357
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclk,
  input  logic              syncPdN,
  input  logic [WORD_W-1:0] convData,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              drdyN,
  output logic              sdo,
  output logic              sdoOe
);
  dpStrobes_t strb;

  sd_adc_ctrl #(
    .FRAME_LEN    (FRAME_LEN),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mclk   (mclk),
    .sclk   (sclk),
    .csN    (csN),
    .syncPdN(syncPdN),
    .drdyN  (drdyN),
    .strb   (strb)
  );

  sd_adc_datapath #(
    .WORD_W(WORD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .convData(convData),
    .sdi     (sdi),
    .sdo     (sdo)
  );

  assign sdoOe = ~csN;

  // R2: the strobe edge and the captured word's MSB arrive together
  assert_msb_on_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> sdo == $past(convData[WORD_W-1]));
endmodule

// File: tb/tb_sd_adc_serial_port.sv
module tb_sd_adc_serial_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mclk = 1'b0;
  logic        syncPdN = 1'b1;
  logic [23:0] convData = 24'h0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        drdyN, sdo, sdoOe;

  int hiLen = 4;
  int loLen = 4;
  int checks = 0;
  int fails = 0;
  int riseCount = 0;
  logic mclkPrev = 1'b0;
  bit done = 1'b0;

  // {hi[3:0], lo[3:0], early[7:0], word[23:0], chain[23:0]}
  localparam logic [63:0] VEC [4] = '{
    {4'd4, 4'd4, 8'd1, 24'hA5C3F0, 24'h3C96E1},
    {4'd4, 4'd4, 8'd0, 24'h800001, 24'hFFFFFF},
    {4'd1, 4'd7, 8'd0, 24'h13579B, 24'h000000},
    {4'd7, 4'd1, 8'd1, 24'h7E5A24, 24'hC0FFEE}
  };

  sd_adc_serial_port dut (
    .clk(clk), .rstN(rstN), .mclk(mclk), .syncPdN(syncPdN), .convData(convData),
    .csN(csN), .sclk(sclk), .sdi(sdi), .drdyN(drdyN), .sdo(sdo), .sdoOe(sdoOe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    mclkPrev <= mclk;
    if (rstN && mclk && !mclkPrev) riseCount <= riseCount + 1;
  end

  initial begin
    wait (rstN);
    forever begin
      repeat (loLen) @(negedge clk);
      mclk = 1'b1;
      repeat (hiLen) @(negedge clk);
      mclk = 1'b0;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitFall();
    logic last;
    do begin
      last = drdyN;
      @(negedge clk);
    end while (!(last === 1'b1 && drdyN === 1'b0));
  endtask

  task automatic sclkPulse(input logic d);
    sdi = d;
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finishRun();
  end

  initial begin
    int base;
    logic [23:0] word, chain;
    logic expBit, held;
    int period, highCnt, lowSeen;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(drdyN === 1'b1, "R9 drdyN in reset", drdyN, 1);
    chk(sdo === 1'b0, "R9 sdo in reset", sdo, 0);
    chk(sdoOe === 1'b0, "R9 R3 sdoOe csN high", sdoOe, 0);
    csN = 1'b0;
    #1;
    chk(sdoOe === 1'b1, "R9 R3 sdoOe csN low", sdoOe, 1);
    @(negedge clk);
    csN = 1'b1;
    rstN = 1'b1;
    base = riseCount;

    // R8: settling after reset
    waitFall();
    chk(riseCount - base == 2357, "R8 settle after reset", riseCount - base, 2357);

    // Table walk: R1-style frame timing, load, shift, chain
    foreach (VEC[i]) begin
      hiLen = int'(VEC[i][63:60]);
      loLen = int'(VEC[i][59:56]);
      word  = VEC[i][47:24];
      chain = VEC[i][23:0];
      convData = word;
      csN = (VEC[i][55:48] != 8'd0) ? 1'b0 : 1'b1;
      waitFall();
      if (!csN) begin
        chk(sdo === word[23], "R2 msb at ready with csN low", sdo, word[23]);
      end else begin
        sclkPulse(1'b1);
        sclkPulse(1'b0);
        sclkPulse(1'b1);
        csN = 1'b0;
        @(negedge clk);
        chk(sdo === word[23], "R5 sclk ignored with csN high", sdo, word[23]);
      end
      for (int k = 0; k < 48; k++) begin
        expBit = (k < 24) ? word[23-k] : chain[47-k];
        chk(sdo === expBit, (k < 24) ? "R4 local word bit" : "R6 chain bit", sdo, expBit);
        sclkPulse((k < 24) ? chain[23-k] : 1'b0);
      end
      csN = 1'b1;
      #1;
      chk(sdoOe === 1'b0, "R3 sdoOe released", sdoOe, 0);
      waitFall();
      period = 0;
      highCnt = 0;
      do begin
        @(negedge clk);
        period++;
        if (drdyN) highCnt++;
      end while (!(drdyN === 1'b0 && highCnt > 0 && period > 1 && highCnt == (hiLen + loLen) && drdyN === 1'b0 && period >= 32 * (hiLen + loLen))
                 && period < 1000);
      chk(period == 32 * (hiLen + loLen), "R1 frame period", period, 32 * (hiLen + loLen));
      chk(highCnt == hiLen + loLen, "R1 high one interval", highCnt, hiLen + loLen);
    end

    // R7: power-down holds the strobe high and loads nothing
    hiLen = 4;
    loLen = 4;
    waitFall();
    csN = 1'b0;
    @(negedge clk);
    held = sdo;
    convData = ~{24{held}};
    syncPdN = 1'b0;
    repeat (16) @(negedge clk);
    chk(drdyN === 1'b1, "R7 drdyN forced high", drdyN, 1);
    lowSeen = 0;
    repeat (320) begin
      @(negedge clk);
      if (drdyN !== 1'b1) lowSeen++;
    end
    chk(lowSeen == 0, "R7 no ready while held", lowSeen, 0);
    chk(sdo === held, "R7 no load while held", sdo, held);
    csN = 1'b1;

    // R8: settling after release
    convData = 24'hB1E2D3;
    syncPdN = 1'b1;
    base = riseCount;
    waitFall();
    chk(riseCount - base == 2358, "R8 settle after release", riseCount - base, 2358);
    csN = 1'b0;
    #1;
    chk(sdo === 1'b1, "R2 first word after settling", sdo, 1);
    csN = 1'b1;

    finishRun();
  end
endmodule